// File: doc/BRIEF.md
# Conditional Control-Transfer Evaluator

This block sits in the decode stage of an 8-bit processor. It looks at an opcode byte, and at whether a prefix byte came before it. It then decides whether a call or branch encoded by that byte is taken. To decide, it uses the Zero, Carry, Overflow and Sign flags, the current B register, and four external condition pins. For the same instruction it also reports the byte length and the cycle cost of the path that is chosen. The block does not push a return address, build a target address or fetch the operand bytes.

Unprefixed calls and branches use a four-way condition set: carry set, carry clear, zero set, zero clear. After the prefix, the low nibble of the second byte selects one of sixteen conditions. Eight of them are signed comparisons and flag tests, and eight test the external pins. There are also three special cases: a decrement-and-branch form that computes B minus one, and two unconditional calls. The result is registered, so it appears one clock after `valid_i` is sampled high and holds while `valid_i` is low.

Top module: `cond_xfer_eval`

## Requirements
- R1: Unprefixed opcodes 0xE0-0xE3 (short call), 0xE4-0xE7 (byte branch), 0xE8-0xEB (long call) and 0xEC-0xEF (word branch) are taken according to opcode bits [1:0]: code 0 means Carry=1, 1 means Carry=0, 2 means Zero=1, 3 means Zero=0.
- R2: With the prefix flag set, second bytes 0xE0-0xEF (branch) and 0xF0-0xFF (call) take the condition picked by bits [3:0]. The codes are: 0 S^V, 1 (S^V)|Z, 2 the inverse of code 1, 3 the inverse of code 0, 4 V, 5 !V, 6 !S, 7 S.
- R3: Prefixed codes 8-11 are taken when external pin (code-8) is low, and codes 12-15 are taken when pin (code-12) is high.
- R4: Conditional calls cost 20 cycles taken and 8 not taken in short form, 24 and 12 in long form, and 24 and 12 in prefixed form.
- R5: Byte branches cost 8 cycles, word branches 12, and prefixed branches 12, whether taken or not.
- R6: Opcode 0xF0 without the prefix is always taken, costs 20 cycles and is 2 bytes long. Opcode 0xF2 is always taken, costs 24 cycles and is 3 bytes long.
- R7: Opcode 0xF5 without the prefix reports B-1 (modulo 256) on `b_next_o`, is taken exactly when that value is nonzero, costs 16 cycles and is 2 bytes long.
- R8: Length is 2 bytes for short calls, byte branches, 0xF0 and 0xF5. It is 3 bytes for long calls, word branches, 0xF2 and every prefixed form.
- R9: Any other opcode, prefixed or not, gives `match_o`=0, `taken_o`=0, length 0 and cycles 0, and `b_next_o` equals B.
- R10: Outputs update on the clock edge after `valid_i` is sampled high, with `out_valid_o` set for that cycle. While `valid_i` is low they keep their value, and reset clears them all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Opcode and state inputs are valid this cycle |
| prefix_i | input | 1 | Opcode byte followed the extension prefix |
| opcode_i | input | 8 | Opcode byte (second byte when prefixed) |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_s_i | input | 1 | Sign flag |
| breg_i | input | DATA_W (8) | Current B register |
| ext_i | input | 4 | External condition pins |
| out_valid_o | output | 1 | Registered result is fresh |
| match_o | output | 1 | Opcode is a handled control transfer |
| taken_o | output | 1 | Transfer is taken |
| len_o | output | LEN_W (2) | Instruction length in bytes |
| cycles_o | output | CYC_W (6) | Cycle cost of the chosen path |
| b_next_o | output | DATA_W (8) | Value of B after the instruction |

## Verification
Every unprefixed opcode from 0xE0 to 0xFF is driven under all sixteen flag combinations. This separates the four condition codes from each other and separates the call and branch cost classes. Every prefixed second byte from 0xE0 to 0xFF is driven under all flag combinations with several external pin patterns, including one-hot and inverted one-hot. Only the correct pin index can then produce the expected result for the external tests. The decrement branch is tried with B at 0, 1, 2 and 0x80, which covers the wrap from 0 and the single value that gives not-taken. Non-transfer opcodes and idle cycles show that nothing unintended is reported and that the outputs hold.

// File: rtl/cte_pkg.sv
package cte_pkg;

   typedef enum logic [3:0] {
      XC_NONE,
      XC_CALL_S,
      XC_CALL_L,
      XC_BR_B,
      XC_BR_W,
      XC_CALL_US,
      XC_CALL_UL,
      XC_DJNZ,
      XC_PCALL,
      XC_PBR
   } xfer_class_e;

   typedef struct packed {
      logic       ext;   // 1: sixteen-entry set, 0: four-entry set
      logic [3:0] idx;
   } cond_sel_t;

   localparam int CYC_CALL_S_HIT  = 20;
   localparam int CYC_CALL_S_MISS = 8;
   localparam int CYC_CALL_L_HIT  = 24;
   localparam int CYC_CALL_L_MISS = 12;
   localparam int CYC_PCALL_HIT   = 24;
   localparam int CYC_PCALL_MISS  = 12;
   localparam int CYC_BR_B        = 8;
   localparam int CYC_BR_W        = 12;
   localparam int CYC_PBR         = 12;
   localparam int CYC_DJNZ        = 16;
   localparam int CYC_MAX         = 24;

   localparam int LEN_SHORT = 2;
   localparam int LEN_LONG  = 3;

endpackage

// File: rtl/cte_decode.sv
module cte_decode
   import cte_pkg::*;
(
   input  logic        prefix_i,
   input  logic [7:0]  opcode_i,
   output xfer_class_e cls_o,
   output cond_sel_t   sel_o
);

   always_comb begin
      cls_o = XC_NONE;
      sel_o = '{ext: prefix_i, idx: 4'h0};
      if (prefix_i) begin
         sel_o.idx = opcode_i[3:0];
         unique case (opcode_i[7:4])
            4'hF:    cls_o = XC_PCALL;
            4'hE:    cls_o = XC_PBR;
            default: cls_o = XC_NONE;
         endcase
      end else begin
         sel_o.idx = {2'b00, opcode_i[1:0]};
         unique case (opcode_i[7:2])
            6'b111000: cls_o = XC_CALL_S;
            6'b111001: cls_o = XC_BR_B;
            6'b111010: cls_o = XC_CALL_L;
            6'b111011: cls_o = XC_BR_W;
            default: begin
               unique case (opcode_i)
                  8'hF0:   cls_o = XC_CALL_US;
                  8'hF2:   cls_o = XC_CALL_UL;
                  8'hF5:   cls_o = XC_DJNZ;
                  default: cls_o = XC_NONE;
               endcase
            end
         endcase
      end
   end

endmodule

// File: rtl/cte_cond.sv
module cte_cond
   import cte_pkg::*;
#(
   parameter int EXT_N = 4
) (
   input  cond_sel_t        sel_i,
   input  logic             z_i,
   input  logic             c_i,
   input  logic             v_i,
   input  logic             s_i,
   input  logic [EXT_N-1:0] ext_i,
   output logic             hit_o
);

   localparam int TAB_N = 2 * EXT_N + 8;

   logic [3:0]       base_tab;
   logic [TAB_N-1:0] ext_tab;
   logic             less, less_eq;

   assign base_tab = {~z_i, z_i, ~c_i, c_i};
   assign less     = s_i ^ v_i;
   assign less_eq  = less | z_i;

   assign ext_tab[0] = less;
   assign ext_tab[1] = less_eq;
   assign ext_tab[2] = ~less_eq;
   assign ext_tab[3] = ~less;
   assign ext_tab[4] = v_i;
   assign ext_tab[5] = ~v_i;
   assign ext_tab[6] = ~s_i;
   assign ext_tab[7] = s_i;

   for (genvar n = 0; n < EXT_N; n++) begin : g_pin
      assign ext_tab[8 + n]         = ~ext_i[n];
      assign ext_tab[8 + EXT_N + n] = ext_i[n];
   end

   assign hit_o = sel_i.ext ? ext_tab[sel_i.idx] : base_tab[sel_i.idx[1:0]];

endmodule

// File: rtl/cte_cost.sv
module cte_cost
   import cte_pkg::*;
#(
   parameter int CYC_W = 6,
   parameter int LEN_W = 2
) (
   input  xfer_class_e      cls_i,
   input  logic             taken_i,
   output logic [CYC_W-1:0] cycles_o,
   output logic [LEN_W-1:0] len_o
);

   localparam logic [LEN_W-1:0] L_S = LEN_W'(LEN_SHORT);
   localparam logic [LEN_W-1:0] L_L = LEN_W'(LEN_LONG);

   function automatic logic [CYC_W-1:0] pick(input logic t, input int hit, input int miss);
      return t ? CYC_W'(hit) : CYC_W'(miss);
   endfunction

   always_comb begin
      cycles_o = '0;
      len_o    = '0;
      unique case (cls_i)
         XC_CALL_S:  begin cycles_o = pick(taken_i, CYC_CALL_S_HIT, CYC_CALL_S_MISS); len_o = L_S; end
         XC_CALL_L:  begin cycles_o = pick(taken_i, CYC_CALL_L_HIT, CYC_CALL_L_MISS); len_o = L_L; end
         XC_PCALL:   begin cycles_o = pick(taken_i, CYC_PCALL_HIT, CYC_PCALL_MISS);   len_o = L_L; end
         XC_BR_B:    begin cycles_o = CYC_W'(CYC_BR_B);       len_o = L_S; end
         XC_BR_W:    begin cycles_o = CYC_W'(CYC_BR_W);       len_o = L_L; end
         XC_PBR:     begin cycles_o = CYC_W'(CYC_PBR);        len_o = L_L; end
         XC_CALL_US: begin cycles_o = CYC_W'(CYC_CALL_S_HIT); len_o = L_S; end
         XC_CALL_UL: begin cycles_o = CYC_W'(CYC_CALL_L_HIT); len_o = L_L; end
         XC_DJNZ:    begin cycles_o = CYC_W'(CYC_DJNZ);       len_o = L_S; end
         default:    begin cycles_o = '0;                     len_o = '0;  end
      endcase
   end

endmodule

// File: rtl/cond_xfer_eval.sv
module cond_xfer_eval
   import cte_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CYC_W   = 6,
   parameter int LEN_W   = 2,
   parameter int EXT_N   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              prefix_i,
   input  logic [7:0]        opcode_i,
   input  logic              flag_z_i,
   input  logic              flag_c_i,
   input  logic              flag_v_i,
   input  logic              flag_s_i,
   input  logic [DATA_W-1:0] breg_i,
   input  logic [EXT_N-1:0]  ext_i,
   output logic              out_valid_o,
   output logic              match_o,
   output logic              taken_o,
   output logic [LEN_W-1:0]  len_o,
   output logic [CYC_W-1:0]  cycles_o,
   output logic [DATA_W-1:0] b_next_o
);

   localparam int CYC_NEED = $clog2(CYC_MAX + 1);
   localparam int RES_W    = 2 + LEN_W + CYC_W + DATA_W;

   if (CYC_W < CYC_NEED) begin : g_chk_cyc
      $error("CYC_W too narrow for the largest cycle cost");
   end
   if (LEN_W < 2) begin : g_chk_len
      $error("LEN_W must hold the value 3");
   end
   if (EXT_N != 4) begin : g_chk_ext
      $error("prefixed condition set needs exactly four external pins");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("DATA_W must be positive");
   end

   xfer_class_e       cls;
   cond_sel_t         sel;
   logic              cond_hit;
   logic              taken_c;
   logic [DATA_W-1:0] b_dec;
   logic [CYC_W-1:0]  cycles_c;
   logic [LEN_W-1:0]  len_c;
   logic [RES_W-1:0]  res_c;

   cte_decode u_decode (
      .prefix_i (prefix_i),
      .opcode_i (opcode_i),
      .cls_o    (cls),
      .sel_o    (sel)
   );

   cte_cond #(.EXT_N(EXT_N)) u_cond (
      .sel_i (sel),
      .z_i   (flag_z_i),
      .c_i   (flag_c_i),
      .v_i   (flag_v_i),
      .s_i   (flag_s_i),
      .ext_i (ext_i),
      .hit_o (cond_hit)
   );

   assign b_dec = breg_i - DATA_W'(1);

   always_comb begin
      unique case (cls)
         XC_NONE:                taken_c = 1'b0;
         XC_CALL_US, XC_CALL_UL: taken_c = 1'b1;
         XC_DJNZ:                taken_c = |b_dec;
         default:                taken_c = cond_hit;
      endcase
   end

   cte_cost #(.CYC_W(CYC_W), .LEN_W(LEN_W)) u_cost (
      .cls_i    (cls),
      .taken_i  (taken_c),
      .cycles_o (cycles_c),
      .len_o    (len_c)
   );

   assign res_c = {(cls != XC_NONE), taken_c, len_c, cycles_c,
                   (cls == XC_DJNZ) ? b_dec : breg_i};

   if (REG_OUT) begin : g_reg
      logic [RES_W-1:0] res_q;
      logic             vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= valid_i;
            if (valid_i) res_q <= res_c;
         end
      end

      assign out_valid_o = vld_q;
      assign {match_o, taken_o, len_o, cycles_o, b_next_o} = res_q;

      // R6: unprefixed short call always taken at 20 cycles
      assert_ucall_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i && !prefix_i && opcode_i == 8'hF0 |=> taken_o && cycles_o == CYC_W'(20) && len_o == LEN_W'(2));

      // R4: prefixed call cost follows outcome
      assert_pcall_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i && prefix_i && opcode_i[7:4] == 4'hF |=>
            match_o && len_o == LEN_W'(3) && (taken_o ? cycles_o == CYC_W'(24) : cycles_o == CYC_W'(12)));

      // R5: prefixed branch cost is fixed
      assert_pbr_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i && prefix_i && opcode_i[7:4] == 4'hE |=> cycles_o == CYC_W'(12));

      // R10: idle cycles keep the result
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> !out_valid_o && $stable(taken_o) && $stable(cycles_o) && $stable(b_next_o));

      // R9: no match means nothing reported
      assert_none_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid_o && !match_o |-> !taken_o && cycles_o == '0 && len_o == '0);

      // R7: decrement branch taken exactly when new B is nonzero
      assert_djnz_R7: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i && !prefix_i && opcode_i == 8'hF5 |=> taken_o == (b_next_o != '0));
   end else begin : g_comb
      assign out_valid_o = valid_i;
      assign {match_o, taken_o, len_o, cycles_o, b_next_o} = res_c;
   end

endmodule

// File: tb/cond_xfer_eval_bench.sv
module cond_xfer_eval_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       valid_i = 1'b0;
   logic       prefix_i = 1'b0;
   logic [7:0] opcode_i = 8'h00;
   logic       fz = 1'b0, fc = 1'b0, fv = 1'b0, fs = 1'b0;
   logic [7:0] breg_i = 8'h00;
   logic [3:0] ext_i = 4'h0;

   logic       out_valid_o, match_o, taken_o;
   logic [1:0] len_o;
   logic [5:0] cycles_o;
   logic [7:0] b_next_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // expected values of the last applied instruction
   int e_match, e_taken, e_len, e_cyc, e_b;
   string e_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_xfer_eval u_cond_xfer_eval (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .prefix_i(prefix_i),
      .opcode_i(opcode_i), .flag_z_i(fz), .flag_c_i(fc), .flag_v_i(fv),
      .flag_s_i(fs), .breg_i(breg_i), .ext_i(ext_i),
      .out_valid_o(out_valid_o), .match_o(match_o), .taken_o(taken_o),
      .len_o(len_o), .cycles_o(cycles_o), .b_next_o(b_next_o)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d (pfx=%0d op=%02h zcvs=%0b%0b%0b%0b b=%02h x=%04b)",
                  tag, what, act, exp, prefix_i, opcode_i, fz, fc, fv, fs, breg_i, ext_i);
      end
   endtask

   // behavioural reference of the requirements
   task automatic model(input bit p, input int op, input bit z, input bit c, input bit v,
                        input bit s, input int b, input bit [3:0] x);
      int  hi, code;
      bit  cnd;
      hi = op / 16;
      e_match = 0; e_taken = 0; e_len = 0; e_cyc = 0; e_b = b; e_tag = "R9";
      if (p) begin
         code = op % 16;
         if (hi == 14 || hi == 15) begin
            if (code < 8) begin
               case (code)
                  0: cnd = (s != v);
                  1: cnd = (s != v) || z;
                  2: cnd = !((s != v) || z);
                  3: cnd = (s == v);
                  4: cnd = v;
                  5: cnd = !v;
                  6: cnd = !s;
                  default: cnd = s;
               endcase
               e_tag = "R2";
            end else begin
               cnd = (code < 12) ? !x[code-8] : x[code-12];
               e_tag = "R3";
            end
            e_match = 1; e_taken = cnd; e_len = 3;
            if (hi == 15) e_cyc = cnd ? 24 : 12;
            else          e_cyc = 12;
         end
      end else if (op >= 8'hE0 && op <= 8'hEF) begin
         code = op % 4;
         cnd = (code == 0) ? c : (code == 1) ? !c : (code == 2) ? z : !z;
         e_match = 1; e_taken = cnd; e_tag = "R1";
         case ((op / 4) % 4)
            0: begin e_len = 2; e_cyc = cnd ? 20 : 8;  end
            1: begin e_len = 2; e_cyc = 8;             end
            2: begin e_len = 3; e_cyc = cnd ? 24 : 12; end
            default: begin e_len = 3; e_cyc = 12;      end
         endcase
      end else if (op == 8'hF0) begin
         e_match = 1; e_taken = 1; e_len = 2; e_cyc = 20; e_tag = "R6";
      end else if (op == 8'hF2) begin
         e_match = 1; e_taken = 1; e_len = 3; e_cyc = 24; e_tag = "R6";
      end else if (op == 8'hF5) begin
         e_b = (b + 255) % 256;
         e_match = 1; e_taken = (e_b != 0); e_len = 2; e_cyc = 16; e_tag = "R7";
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "out_valid", out_valid_o, 1);
      chk(tag, "match", match_o, e_match);
      chk(tag, "taken", taken_o, e_taken);
      chk({tag, "/R8"}, "len", len_o, e_len);
      chk({tag, "/R4R5"}, "cycles", cycles_o, e_cyc);
      chk(tag, "b_next", b_next_o, e_b);
   endtask

   // called at a falling edge; result sampled at the next falling edge
   task automatic apply(input bit p, input int op, input bit [3:0] zcvs, input int b, input bit [3:0] x);
      valid_i = 1'b1; prefix_i = p; opcode_i = op[7:0];
      fz = zcvs[3]; fc = zcvs[2]; fv = zcvs[1]; fs = zcvs[0];
      breg_i = b[7:0]; ext_i = x;
      model(p, op, zcvs[3], zcvs[2], zcvs[1], zcvs[0], b, x);
      @(negedge clk);
      compare_all(e_tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", "rst out_valid", out_valid_o, 0);
      chk("R10", "rst taken", taken_o, 0);
      chk("R10", "rst cycles", cycles_o, 0);
      chk("R10", "rst b_next", b_next_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R4 R5 R6 R7 R8: every unprefixed E0..FF under all flags
      for (int op = 8'hE0; op <= 8'hFF; op++)
         for (int f = 0; f < 16; f++)
            apply(1'b0, op, f[3:0], 8'h5A, 4'h0);

      // R2 R3 R4 R5: prefixed E0..FF, all flags, several pin patterns
      for (int op = 8'hE0; op <= 8'hFF; op++)
         for (int f = 0; f < 16; f++)
            for (int k = 0; k < 6; k++)
               apply(1'b1, op, f[3:0], 8'h33,
                     (k < 4) ? 4'(1 << k) : ((k == 4) ? 4'hE : 4'h7));

      // R7 decrement boundaries
      apply(1'b0, 8'hF5, 4'h0, 8'h00, 4'h0);
      apply(1'b0, 8'hF5, 4'hF, 8'h01, 4'h0);
      apply(1'b0, 8'hF5, 4'h0, 8'h02, 4'h0);
      apply(1'b0, 8'hF5, 4'h0, 8'h80, 4'h0);

      // R9 non-transfer opcodes
      apply(1'b0, 8'h00, 4'hF, 8'h11, 4'hF);
      apply(1'b0, 8'hF1, 4'hF, 8'h12, 4'hF);
      apply(1'b0, 8'hDF, 4'h0, 8'h13, 4'h0);
      apply(1'b1, 8'h12, 4'hF, 8'h14, 4'hF);
      apply(1'b1, 8'hD8, 4'h5, 8'h15, 4'hA);

      // R10 hold while idle: last result was a taken prefixed call
      apply(1'b1, 8'hFC, 4'h0, 8'h20, 4'h1);
      valid_i = 1'b0; prefix_i = 1'b0; opcode_i = 8'hF5; breg_i = 8'h01;
      @(negedge clk);
      chk("R10", "idle out_valid", out_valid_o, 0);
      chk("R10", "idle taken", taken_o, 1);
      chk("R10", "idle cycles", cycles_o, 24);
      chk("R10", "idle b_next", b_next_o, 8'h20);
      @(negedge clk);
      chk("R10", "idle2 len", len_o, 3);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule